// File: doc/BRIEF.md
# Boot Table Bytecode Interpreter

This block walks an initialisation table held in memory and carries out its entries one after another. Each entry is nine bytes long. The first byte is the operation code. Two 32-bit operands follow, each stored least significant byte first. The interpreter keeps a 32-bit accumulator and a table pointer. It reaches the outside world through four request/acknowledge ports: a byte-wide table fetch port, a memory word port, a byte-wide I/O port and a configuration-space port. The configuration port exposes an address register and a data register, selected by `cfg_sel_o`.

A host pulses `start_i` with the table start address and an allowed window. The interpreter runs until it meets the end operation, which raises `done_o`. If an entry would start outside the window, it raises `err_o` instead. An indirect prefix lets an entry use the current accumulator as its source operand or as its branch offset. Relative branches are taken from the address of the following entry.

Top module: `boot_seq`

## Requirements
- R1: While reset is held and after it is released, no request is raised, `busy_o`, `done_o` and `err_o` are low and `acc_o` is zero.
- R2: An entry at pointer P is fetched as nine byte reads at P..P+8. Byte 0 is the operation code, bytes 1..4 are operand A (LSB first) and bytes 5..8 are operand B (LSB first).
- R3: Code 0x03 writes operand A to memory address B. Code 0x09 loads the memory word at address B into the accumulator.
- R4: Code 0x02 writes the low byte of A to I/O address B. Code 0x08 loads the I/O byte at address B into the accumulator, zero-extended.
- R5: Code 0x01 makes three configuration writes in this order: the address register (`cfg_sel_o`=0) with B, the data register (`cfg_sel_o`=1) with A, then the address register with zero.
- R6: Code 0x05 writes B to the configuration address register, then reads the data register into the accumulator.
- R7: Code 0x06 sets the accumulator to (accumulator AND B) OR A.
- R8: Code 0x07 always jumps, and code 0x04 jumps only when the accumulator differs from B. The target is P + 9 + A, modulo 2^32. When no jump is taken, execution continues at P + 9.
- R9: Code 0xE1 is a prefix. It executes the operation named by the low byte of B, using B := A and A := accumulator.
- R10: Code 0xEE stops execution and holds `done_o` until the next start. Every code not named in R3 to R9, and not 0x01 or 0xEE, does nothing except advance the pointer by 9.
- R11: If an entry's start P lies below `win_lo_i`, or P + 9 exceeds `win_hi_i`, the block raises `err_o` without making any fetch for that entry. `done_o` stays low.
- R12: Only one request is active at a time. A request keeps its address and data until it is acknowledged. The block makes no further fetch until the acknowledgement arrives.
- R13: A start pulse while the block is idle, done or in error loads the pointer from `base_i`, clears the accumulator, `done_o` and `err_o`, and begins fetching. A start pulse while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| base_i | input | 32 | Table start address |
| win_lo_i | input | 32 | Lowest allowed entry address |
| win_hi_i | input | 32 | Exclusive upper bound of the table window |
| fch_req_o | output | 1 | Table byte read request |
| fch_addr_o | output | 32 | Table byte address |
| fch_vld_i | input | 1 | Table byte valid |
| fch_data_i | input | 8 | Table byte |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data |
| io_req_o | output | 1 | I/O request |
| io_we_o | output | 1 | I/O write (1) or read (0) |
| io_addr_o | output | 32 | I/O address |
| io_wdata_o | output | 8 | I/O write byte |
| io_ack_i | input | 1 | I/O acknowledge |
| io_rdata_i | input | 8 | I/O read byte |
| cfg_req_o | output | 1 | Configuration request |
| cfg_we_o | output | 1 | Configuration write (1) or read (0) |
| cfg_sel_o | output | 1 | 0 selects the address register, 1 selects the data register |
| cfg_wdata_o | output | 32 | Configuration write data |
| cfg_ack_i | input | 1 | Configuration acknowledge |
| cfg_rdata_i | input | 32 | Configuration read data |
| busy_o | output | 1 | Table is being run |
| done_o | output | 1 | End operation reached |
| err_o | output | 1 | Pointer left the window |
| acc_o | output | 32 | Accumulator |

## Verification
Two paths are hard to reach from the ports. The first is the prefixed branch, whose offset comes from the accumulator. The second is the window error raised by a jump target rather than by the start address. The bench reaches both with short tables: an AND/OR entry first loads a known value into the accumulator, then a prefixed not-equal branch uses it to skip an entry, and a forward jump lands beyond the window bound. The third step of the configuration write only shows up when the acknowledgement is late, so the responders run at programmable latencies from zero to three cycles. The same single-entry table is also run for every unrecognised operation code.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam logic [7:0] OP_CFG_WR = 8'h01;
  localparam logic [7:0] OP_IO_WR  = 8'h02;
  localparam logic [7:0] OP_MEM_WR = 8'h03;
  localparam logic [7:0] OP_BNE    = 8'h04;
  localparam logic [7:0] OP_CFG_RD = 8'h05;
  localparam logic [7:0] OP_ANDOR  = 8'h06;
  localparam logic [7:0] OP_BRA    = 8'h07;
  localparam logic [7:0] OP_IO_RD  = 8'h08;
  localparam logic [7:0] OP_MEM_RD = 8'h09;
  localparam logic [7:0] OP_IND    = 8'hE1;
  localparam logic [7:0] OP_END    = 8'hEE;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_EXEC, S_CFG_A, S_CFG_D, S_CFG_Z, S_MEM, S_IO, S_DONE, S_ERR
  } state_e;
endpackage

// File: rtl/boot_seq_decode.sv
module boot_seq_decode
  import boot_seq_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned IW = 8 + 2 * DW
) (
  input  logic [IW-1:0] ins_i,
  input  logic [DW-1:0] acc_i,
  output logic [7:0]    op_o,
  output logic [DW-1:0] op1_o,
  output logic [DW-1:0] op2_o
);
  logic [7:0]    raw;
  logic [DW-1:0] a, b;

  assign raw = ins_i[7:0];
  assign a   = ins_i[8 +: DW];
  assign b   = ins_i[8 + DW +: DW];

  // prefix: real code in low byte of B, operands shift toward B
  always_comb begin
    if (raw == OP_IND) begin
      op_o  = b[7:0];
      op1_o = acc_i;
      op2_o = a;
    end else begin
      op_o  = raw;
      op1_o = a;
      op2_o = b;
    end
  end
endmodule

// File: rtl/boot_seq_alu.sv
module boot_seq_alu
  import boot_seq_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned IB = 9
) (
  input  logic [DW-1:0] pc_i,
  input  logic [7:0]    op_i,
  input  logic [DW-1:0] op1_i,
  input  logic [DW-1:0] op2_i,
  input  logic [DW-1:0] acc_i,
  output logic [DW-1:0] seq_pc_o,
  output logic [DW-1:0] jmp_pc_o,
  output logic          taken_o,
  output logic [DW-1:0] andor_o
);
  assign seq_pc_o = pc_i + DW'(IB);
  assign jmp_pc_o = seq_pc_o + op1_i;
  assign taken_o  = (op_i == OP_BRA) || ((op_i == OP_BNE) && (acc_i != op2_i));
  assign andor_o  = (acc_i & op2_i) | op1_i;
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_seq_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned IOW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [DW-1:0]  base_i,
  input  logic [DW-1:0]  win_lo_i,
  input  logic [DW-1:0]  win_hi_i,
  output logic           fch_req_o,
  output logic [DW-1:0]  fch_addr_o,
  input  logic           fch_vld_i,
  input  logic [7:0]     fch_data_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [DW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic           mem_ack_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           io_req_o,
  output logic           io_we_o,
  output logic [DW-1:0]  io_addr_o,
  output logic [IOW-1:0] io_wdata_o,
  input  logic           io_ack_i,
  input  logic [IOW-1:0] io_rdata_i,
  output logic           cfg_req_o,
  output logic           cfg_we_o,
  output logic           cfg_sel_o,
  output logic [DW-1:0]  cfg_wdata_o,
  input  logic           cfg_ack_i,
  input  logic [DW-1:0]  cfg_rdata_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic [DW-1:0]  acc_o
);
  localparam int unsigned IB  = 1 + 2 * (DW / 8);
  localparam int unsigned IW  = 8 * IB;
  localparam int unsigned IXW = $clog2(IB);

  state_e         st_q;
  logic [DW-1:0]  pc_q, acc_q, op1_q, op2_q;
  logic [IW-1:0]  ins_q;
  logic [IXW-1:0] ix_q;
  logic           rd_q;

  logic [7:0]     d_op;
  logic [DW-1:0]  d_op1, d_op2, seq_pc, jmp_pc, andor;
  logic           taken, in_win;

  boot_seq_decode #(.DW(DW)) u_dec (
    .ins_i(ins_q), .acc_i(acc_q), .op_o(d_op), .op1_o(d_op1), .op2_o(d_op2)
  );

  boot_seq_alu #(.DW(DW), .IB(IB)) u_alu (
    .pc_i(pc_q), .op_i(d_op), .op1_i(d_op1), .op2_i(d_op2), .acc_i(acc_q),
    .seq_pc_o(seq_pc), .jmp_pc_o(jmp_pc), .taken_o(taken), .andor_o(andor)
  );

  // whole entry must fit inside [lo, hi)
  assign in_win = ({1'b0, pc_q} >= {1'b0, win_lo_i}) &&
                  ({1'b0, pc_q} + (DW+1)'(IB) <= {1'b0, win_hi_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      pc_q  <= '0;
      acc_q <= '0;
      op1_q <= '0;
      op2_q <= '0;
      ins_q <= '0;
      ix_q  <= '0;
      rd_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE, S_DONE, S_ERR: begin
          if (start_i) begin
            pc_q  <= base_i;
            acc_q <= '0;
            ix_q  <= '0;
            st_q  <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (!in_win) begin
            st_q <= S_ERR;
          end else if (fch_vld_i) begin
            ins_q[{ix_q, 3'b000} +: 8] <= fch_data_i;
            if (ix_q == IXW'(IB - 1)) begin
              ix_q <= '0;
              st_q <= S_EXEC;
            end else begin
              ix_q <= ix_q + 1'b1;
            end
          end
        end
        S_EXEC: begin
          op1_q <= d_op1;
          op2_q <= d_op2;
          rd_q  <= 1'b0;
          pc_q  <= taken ? jmp_pc : seq_pc;
          case (d_op)
            OP_CFG_WR: st_q <= S_CFG_A;
            OP_CFG_RD: begin rd_q <= 1'b1; st_q <= S_CFG_A; end
            OP_IO_WR:  st_q <= S_IO;
            OP_IO_RD:  begin rd_q <= 1'b1; st_q <= S_IO; end
            OP_MEM_WR: st_q <= S_MEM;
            OP_MEM_RD: begin rd_q <= 1'b1; st_q <= S_MEM; end
            OP_ANDOR:  begin acc_q <= andor; st_q <= S_FETCH; end
            OP_END:    st_q <= S_DONE;
            default:   st_q <= S_FETCH;
          endcase
        end
        S_CFG_A: if (cfg_ack_i) st_q <= S_CFG_D;
        S_CFG_D: begin
          if (cfg_ack_i) begin
            if (rd_q) begin
              acc_q <= cfg_rdata_i;
              st_q  <= S_FETCH;
            end else begin
              st_q  <= S_CFG_Z;
            end
          end
        end
        S_CFG_Z: if (cfg_ack_i) st_q <= S_FETCH;
        S_MEM: begin
          if (mem_ack_i) begin
            if (rd_q) acc_q <= mem_rdata_i;
            st_q <= S_FETCH;
          end
        end
        S_IO: begin
          if (io_ack_i) begin
            if (rd_q) acc_q <= DW'(io_rdata_i);
            st_q <= S_FETCH;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign fch_req_o  = (st_q == S_FETCH) && in_win;
  assign fch_addr_o = pc_q + DW'(ix_q);

  assign mem_req_o   = (st_q == S_MEM);
  assign mem_we_o    = !rd_q;
  assign mem_addr_o  = op2_q;
  assign mem_wdata_o = op1_q;

  assign io_req_o   = (st_q == S_IO);
  assign io_we_o    = !rd_q;
  assign io_addr_o  = op2_q;
  assign io_wdata_o = op1_q[IOW-1:0];

  assign cfg_req_o = (st_q == S_CFG_A) || (st_q == S_CFG_D) || (st_q == S_CFG_Z);
  assign cfg_sel_o = (st_q == S_CFG_D);
  assign cfg_we_o  = !((st_q == S_CFG_D) && rd_q);
  always_comb begin
    case (st_q)
      S_CFG_A: cfg_wdata_o = op2_q;
      S_CFG_D: cfg_wdata_o = op1_q;
      default: cfg_wdata_o = '0;
    endcase
  end

  assign busy_o = !((st_q == S_IDLE) || (st_q == S_DONE) || (st_q == S_ERR));
  assign done_o = (st_q == S_DONE);
  assign err_o  = (st_q == S_ERR);
  assign acc_o  = acc_q;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          fch_req_o,
  input logic          fch_vld_i,
  input logic [DW-1:0] fch_addr_o,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          io_req_o,
  input logic          cfg_req_o,
  input logic          cfg_ack_i,
  input logic          cfg_we_o,
  input logic          cfg_sel_o,
  input logic [DW-1:0] cfg_wdata_o,
  input logic          done_o,
  input logic          err_o
);
  a_r12_one_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fch_req_o, mem_req_o, io_req_o, cfg_req_o}));

  a_r12_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r2_fetch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fch_req_o && !fch_vld_i |=> fch_req_o && $stable(fch_addr_o));

  a_r5_addr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_ack_i && cfg_we_o && cfg_sel_o |=>
      cfg_req_o && cfg_we_o && !cfg_sel_o && (cfg_wdata_o == '0));

  a_r10_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  a_r10_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(fch_req_o || mem_req_o || io_req_o || cfg_req_o));

  a_r11_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !(fch_req_o || mem_req_o || io_req_o || cfg_req_o || done_o));
endmodule

bind boot_seq boot_seq_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .fch_req_o(fch_req_o), .fch_vld_i(fch_vld_i), .fch_addr_o(fch_addr_o),
  .mem_req_o(mem_req_o), .mem_ack_i(mem_ack_i), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .io_req_o(io_req_o), .cfg_req_o(cfg_req_o), .cfg_ack_i(cfg_ack_i),
  .cfg_we_o(cfg_we_o), .cfg_sel_o(cfg_sel_o), .cfg_wdata_o(cfg_wdata_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/sim_boot_seq.sv
`timescale 1ns/1ps
module sim_boot_seq;
  localparam logic [31:0] B = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 1'b0;
  logic [31:0] base = '0, lo = 32'h100, hi = 32'h300;
  logic        fch_req, mem_req, mem_we, io_req, io_we, cfg_req, cfg_we, cfg_sel;
  logic [31:0] fch_addr, mem_addr, mem_wdata, io_addr, cfg_wdata, acc;
  logic [7:0]  io_wdata;
  logic        busy, done, err;
  logic        fch_vld = 1'b0, mem_ack = 1'b0, io_ack = 1'b0, cfg_ack = 1'b0;
  logic [7:0]  fch_data = '0, io_rdata = '0;
  logic [31:0] mem_rdata = '0, cfg_rdata = '0;

  boot_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
    .win_lo_i(lo), .win_hi_i(hi),
    .fch_req_o(fch_req), .fch_addr_o(fch_addr), .fch_vld_i(fch_vld), .fch_data_i(fch_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .io_req_o(io_req), .io_we_o(io_we), .io_addr_o(io_addr), .io_wdata_o(io_wdata),
    .io_ack_i(io_ack), .io_rdata_i(io_rdata),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_sel_o(cfg_sel), .cfg_wdata_o(cfg_wdata),
    .cfg_ack_i(cfg_ack), .cfg_rdata_i(cfg_rdata),
    .busy_o(busy), .done_o(done), .err_o(err), .acc_o(acc)
  );

  logic [7:0]  tbl [0:1023];
  logic [31:0] memw [0:63];
  logic [7:0]  iob [0:255];
  logic [31:0] fch_log [0:15];
  logic        cfg_lsel [0:7];
  logic        cfg_lwe [0:7];
  logic [31:0] cfg_ldat [0:7];
  logic [31:0] cfg_cur = '0;
  int lat = 0;
  int fc = 0, mc = 0, ic = 0, cc = 0;
  int n_fch = 0, n_mem = 0, n_io = 0, n_cfg = 0;
  int nchk = 0, nerr = 0;

  // responders: acknowledge after lat waiting cycles, for one cycle
  always @(posedge clk) begin
    if (fch_vld) begin
      fch_vld <= 1'b0; fc <= 0;
      if (n_fch < 16) fch_log[n_fch] <= fch_addr;
      n_fch <= n_fch + 1;
    end else if (fch_req) begin
      if (fc >= lat) begin fch_vld <= 1'b1; fch_data <= tbl[fch_addr[9:0]]; end
      else fc <= fc + 1;
    end
  end

  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0; mc <= 0; n_mem <= n_mem + 1;
      if (mem_we) memw[mem_addr[7:2]] <= mem_wdata;
    end else if (mem_req) begin
      if (mc >= lat) begin mem_ack <= 1'b1; mem_rdata <= memw[mem_addr[7:2]]; end
      else mc <= mc + 1;
    end
  end

  always @(posedge clk) begin
    if (io_ack) begin
      io_ack <= 1'b0; ic <= 0; n_io <= n_io + 1;
      if (io_we) iob[io_addr[7:0]] <= io_wdata;
    end else if (io_req) begin
      if (ic >= lat) begin io_ack <= 1'b1; io_rdata <= iob[io_addr[7:0]]; end
      else ic <= ic + 1;
    end
  end

  always @(posedge clk) begin
    if (cfg_ack) begin
      cfg_ack <= 1'b0; cc <= 0;
      if (n_cfg < 8) begin
        cfg_lsel[n_cfg] <= cfg_sel; cfg_lwe[n_cfg] <= cfg_we; cfg_ldat[n_cfg] <= cfg_wdata;
      end
      n_cfg <= n_cfg + 1;
      if (cfg_we && !cfg_sel) cfg_cur <= cfg_wdata;
    end else if (cfg_req) begin
      if (cc >= lat) begin cfg_ack <= 1'b1; cfg_rdata <= cfg_cur ^ 32'hA5A5_A5A5; end
      else cc <= cc + 1;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [7:0] op, input logic [31:0] o1, input logic [31:0] o2);
    tbl[a] = op;
    for (int k = 0; k < 4; k++) begin
      tbl[a + 1 + k] = o1[8*k +: 8];
      tbl[a + 5 + k] = o2[8*k +: 8];
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 1024; i++) tbl[i] = 8'hEE;
    for (int i = 0; i < 64; i++) memw[i] = '0;
    for (int i = 0; i < 256; i++) iob[i] = '0;
  endtask

  task automatic run(input logic [31:0] b);
    n_fch = 0; n_mem = 0; n_io = 0; n_cfg = 0;
    base = b;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (done || err) break;
      @(negedge clk);
    end
    if (!(done || err)) begin
      nchk++; nerr++;
      $display("FAIL R10 timeout act=busy exp=finished");
    end
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {25'd0, busy, done, err, fch_req, mem_req, io_req, cfg_req}, '0);
    chk("R1 acc in reset", acc, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 outputs after reset", {25'd0, busy, done, err, fch_req, mem_req, io_req, cfg_req}, '0);

    // R3 / R12 across latencies, R2 byte addressing
    for (int l = 0; l < 4; l++) begin
      logic [31:0] v;
      v = 32'hCAFE_0000 + 32'(l * 32'h1111);
      lat = l; clr();
      put(B, 8'h03, v, 32'h40);
      put(B + 9, 8'h09, 32'h0, 32'h40);
      run(B);
      chk("R3 memory word written", memw[16], v);
      chk("R3 acc loaded", acc, v);
      chk("R12 memory accesses", 32'(n_mem), 32'd2);
      chk("R12 fetch count", 32'(n_fch), 32'd27);
      if (l == 0)
        for (int k = 0; k < 9; k++) chk("R2 fetch address", fch_log[k], B + 32'(k));
    end

    // R4
    lat = 1; clr(); iob[8'h20] = 8'hC3;
    put(B, 8'h02, 32'h00AB_CD5A, 32'h12);
    put(B + 9, 8'h08, 32'hFFFF_FFFF, 32'h20);
    run(B);
    chk("R4 io byte written", 32'(iob[8'h12]), 32'h5A);
    chk("R4 io byte loaded zero-extended", acc, 32'h0000_00C3);

    // R5
    for (int l = 0; l < 3; l++) begin
      lat = l; clr();
      put(B, 8'h01, 32'h1234_5678, 32'h8000_0810);
      run(B);
      chk("R5 config access count", 32'(n_cfg), 32'd3);
      chk("R5 step1 addr reg", {cfg_lwe[0], cfg_lsel[0]} == 2'b10 ? cfg_ldat[0] : 32'hDEAD_DEAD, 32'h8000_0810);
      chk("R5 step2 data reg", {cfg_lwe[1], cfg_lsel[1]} == 2'b11 ? cfg_ldat[1] : 32'hDEAD_DEAD, 32'h1234_5678);
      chk("R5 step3 addr zero", {cfg_lwe[2], cfg_lsel[2]} == 2'b10 ? cfg_ldat[2] : 32'hDEAD_DEAD, 32'h0);
    end

    // R6
    lat = 2; clr();
    put(B, 8'h05, 32'h0, 32'h8000_0004);
    run(B);
    chk("R6 config access count", 32'(n_cfg), 32'd2);
    chk("R6 addr write", {cfg_lwe[0], cfg_lsel[0]} == 2'b10 ? cfg_ldat[0] : 32'hDEAD_DEAD, 32'h8000_0004);
    chk("R6 data read into acc", acc, 32'h8000_0004 ^ 32'hA5A5_A5A5);

    // R7 sweep
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a, o1, o2;
      a  = 32'h9E37_79B9 * 32'(i + 1);
      o1 = (32'h0101_0101 << i) & 32'h0F0F_F00F;
      o2 = ~(32'h1357_9BDF * 32'(i + 3));
      lat = i % 3; clr(); memw[12] = a;
      put(B, 8'h09, 32'h0, 32'h30);
      put(B + 9, 8'h06, o1, o2);
      run(B);
      chk("R7 and-or result", acc, (a & o2) | o1);
    end

    // R8 branches
    lat = 0; clr(); memw[0] = 32'd5;
    put(B,      8'h09, 32'h0, 32'h0);
    put(B + 9,  8'h04, 32'd9, 32'd5);
    put(B + 18, 8'h03, 32'd1, 32'h10);
    put(B + 27, 8'h04, 32'd9, 32'd7);
    put(B + 36, 8'h03, 32'd2, 32'h14);
    put(B + 45, 8'h07, 32'd9, 32'h0);
    put(B + 54, 8'h03, 32'd3, 32'h18);
    run(B);
    chk("R8 bne not taken on equal", memw[4], 32'd1);
    chk("R8 bne taken skips", memw[5], 32'd0);
    chk("R8 bra skips", memw[6], 32'd0);
    chk("R8 reached end", 32'(done), 32'd1);

    clr();
    put(B,      8'h07, 32'd9, 32'h0);
    put(B + 9,  8'hEE, 32'h0, 32'h0);
    put(B + 18, 8'h03, 32'd4, 32'h1C);
    put(B + 27, 8'h07, -32'sd27, 32'h0);
    put(B + 36, 8'h03, 32'd5, 32'h20);
    run(B);
    chk("R8 forward target", memw[7], 32'd4);
    chk("R8 backward target", memw[8], 32'd0);
    chk("R8 fetch count", 32'(n_fch), 32'd36);

    // R9 prefix
    lat = 1; clr();
    put(B,      8'h06, 32'd9, 32'h0);
    put(B + 9,  8'hE1, 32'd5, 32'h04);
    put(B + 18, 8'h03, 32'h0BAD, 32'h24);
    put(B + 27, 8'hE1, 32'h28, 32'h03);
    run(B);
    chk("R9 prefixed branch skipped", memw[9], 32'd0);
    chk("R9 prefixed store of acc", memw[10], 32'd9);
    chk("R9 acc", acc, 32'd9);

    // R10 sweep of unrecognised codes
    for (int op = 0; op < 256; op++) begin
      if ((op >= 1 && op <= 9) || op == 8'hE1 || op == 8'hEE) continue;
      lat = op % 3; clr();
      put(B, 8'(op), 32'h1122_3344, 32'h40);
      run(B);
      chk($sformatf("R10 nop 0x%02h", op),
          {7'd0, done, 8'(n_mem + n_io + n_cfg), 8'(n_fch), acc[7:0]},
          {7'd0, 1'b1, 8'd0, 8'd18, 8'd0});
    end

    // R11 window
    lat = 0; clr();
    run(32'h2F8);
    chk("R11 start past window", {30'd0, err, done}, 32'b10);
    chk("R11 no fetch", 32'(n_fch), 32'd0);
    run(32'hFF);
    chk("R11 start below window", {30'd0, err, done}, 32'b10);
    run(32'h2F7);
    chk("R11 last entry fits", {30'd0, err, done}, 32'b01);
    clr();
    put(B, 8'h07, 32'h1000, 32'h0);
    run(B);
    chk("R11 jump out of window", {30'd0, err, done}, 32'b10);
    chk("R11 fetches before error", 32'(n_fch), 32'd9);

    // R13 restart clears state
    clr();
    put(B, 8'h06, 32'h77, 32'h0);
    run(B);
    chk("R13 acc before restart", acc, 32'h77);
    tbl[B] = 8'hEE;
    run(B);
    chk("R13 acc cleared", acc, 32'h0);
    chk("R13 err cleared", {30'd0, err, done}, 32'b01);

    // R13 start while busy is ignored
    clr(); lat = 3;
    put(B, 8'h03, 32'hA1, 32'h2C);
    put(B + 9, 8'h03, 32'hB2, 32'h2C);
    base = B; n_fch = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (6) @(negedge clk);
    base = B + 9;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R13 busy start ignored", memw[11], 32'hB2);
    chk("R13 busy start fetch count", 32'(n_fch), 32'd27);

    summary();
    $finish;
  end
endmodule